// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is the control window of a shared-memory device that links two software domains. A bus master reaches it through a simple request interface carrying an access size of byte, halfword or word. Inside the 256-byte window sit a 16-bit interrupt enable mask and a 16-bit interrupt cause register. One level-sensitive interrupt line is driven from the two of them.

The status register does not accumulate cause bits. Each byte that arrives from the peer replaces it, and a halfword read of status returns the value and empties the register. A byte write to the doorbell location stores nothing. It sends the low data byte to the peer as a one-byte outbound message.

Read data is registered. It appears in the cycle after the read request and is zero in every other cycle. The outbound message is a one-cycle valid pulse with its byte. The inbound side is always ready.

Top module: `dbell_regblk`

## Requirements
- R1: While rst_ni is low, mask and status are zero and irq_o, tx_valid_o, tx_data_o and rdata_o are all zero.
- R2: irq_o is high exactly when the bitwise AND of status and mask is nonzero, following the register contents with no extra cycle.
- R3: A halfword write (size_i=1) replaces the mask with wdata_i[15:0] when address bits [7:1] select offset 0, and replaces status when they select offset 16. Address bit 0 and bits above bit 7 are ignored.
- R4: A halfword read at exact offset 0 returns the mask on rdata_o[15:0] in the next cycle. A halfword read at exact offset 16 returns status the same way and clears status to zero at that edge. The upper rdata_o bits are zero.
- R5: A halfword read at any other offset returns zero and changes no state. This includes offsets 1, 17 and 32.
- R6: A byte write (size_i=0) at offset 32 raises tx_valid_o for exactly the next cycle, with tx_data_o equal to wdata_i[7:0]. tx_data_o keeps that value until the next doorbell write. Back-to-back doorbell writes give back-to-back pulses.
- R7: rx_valid_i loads status with {8'h00, rx_data_i} at the next edge. It takes priority over a status write or a status read-clear in the same cycle, and the read still returns the old value.
- R8: Word (size_i=2) and reserved-size (size_i=3) accesses, byte reads, byte writes away from offset 32 and halfword writes to offsets other than 0 and 16 change no register, send no message and read as zero.
- R9: rdata_o is zero in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access request, one access per cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| addr_i | input | ADDR_W | Byte address; only bits [7:0] are decoded |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data, valid the cycle after a read |
| irq_o | output | 1 | Level interrupt |
| tx_valid_o | output | 1 | Outbound message pulse |
| tx_data_o | output | 8 | Outbound message byte |
| rx_valid_i | input | 1 | Inbound message strobe |
| rx_data_i | input | 8 | Inbound message byte |

## Verification
On every cycle the checker confirms several things. A doorbell pulse and its byte must trace back to a byte doorbell write one cycle earlier, and an inbound byte must land in status. A status read must leave status empty, and word accesses must leave everything untouched. Idle cycles must read zero, and the interrupt must never rise with a zero mask or zero status. The bench scenarios add what a single-cycle property cannot show. These are the values read back after a sequence of writes, the treatment of address bit 0 on reads versus writes, and the priority order when an inbound byte meets a status read or write. A reset in the middle of a run, and a long random mix of accesses compared against the behavioural model, are covered there as well.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int unsigned OFF_W = 8;
  localparam logic [OFF_W-1:0] OFF_MASK = 8'h00;
  localparam logic [OFF_W-1:0] OFF_STAT = 8'h10;
  localparam logic [OFF_W-1:0] OFF_BELL = 8'h20;

  typedef struct packed {
    logic mask_wr;
    logic stat_wr;
    logic mask_rd;
    logic stat_rd;
    logic bell_wr;
  } acc_dec_t;
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              req_i,
  input  logic              we_i,
  input  acc_size_e         size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_dec_t          dec_o
);
  logic [OFF_W-1:0] off, hoff;
  logic             is_half, is_byte;
  logic             unused_hi;

  assign off       = addr_i[OFF_W-1:0];
  assign hoff      = {off[OFF_W-1:1], 1'b0};  // writes drop bit 0, reads do not
  assign is_half   = req_i && (size_i == SZ_HALF);
  assign is_byte   = req_i && (size_i == SZ_BYTE);
  assign unused_hi = ^addr_i[ADDR_W-1:OFF_W];

  always_comb begin
    dec_o         = '0;
    dec_o.mask_wr = is_half &&  we_i && (hoff == OFF_MASK);
    dec_o.stat_wr = is_half &&  we_i && (hoff == OFF_STAT);
    dec_o.mask_rd = is_half && !we_i && (off  == OFF_MASK);
    dec_o.stat_rd = is_half && !we_i && (off  == OFF_STAT);
    dec_o.bell_wr = is_byte &&  we_i && (off  == OFF_BELL);
  end
endmodule

// File: rtl/dbell_irq_regs.sv
module dbell_irq_regs
  import dbell_pkg::*;
#(
  parameter int unsigned REG_W = 16,
  parameter int unsigned MSG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  acc_dec_t         dec_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             rx_valid_i,
  input  logic [MSG_W-1:0] rx_data_i,
  output logic [REG_W-1:0] mask_o,
  output logic [REG_W-1:0] stat_o,
  output logic             irq_o
);
  localparam int unsigned PAD_W = REG_W - MSG_W;

  logic [REG_W-1:0] mask_q, stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (dec_i.mask_wr) mask_q <= wdata_i;
      // peer byte beats any bus action on status
      if (rx_valid_i)          stat_q <= {{PAD_W{1'b0}}, rx_data_i};
      else if (dec_i.stat_wr)  stat_q <= wdata_i;
      else if (dec_i.stat_rd)  stat_q <= '0;
    end
  end

  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & mask_q);
endmodule

// File: rtl/dbell_tx.sv
module dbell_tx #(
  parameter int unsigned MSG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [MSG_W-1:0] data_i,
  output logic             valid_o,
  output logic [MSG_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/dbell_regblk.sv
module dbell_regblk
  import dbell_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned MSG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              tx_valid_o,
  output logic [MSG_W-1:0]  tx_data_o,
  input  logic              rx_valid_i,
  input  logic [MSG_W-1:0]  rx_data_i
);
  localparam int unsigned RPAD_W = DATA_W - REG_W;

  acc_dec_t          dec;
  logic [REG_W-1:0]  mask_q, stat_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              unused_wd;

  assign unused_wd = ^wdata_i[DATA_W-1:REG_W];

  dbell_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_i  (req_i),
    .we_i   (we_i),
    .size_i (acc_size_e'(size_i)),
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  dbell_irq_regs #(.REG_W(REG_W), .MSG_W(MSG_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dec_i      (dec),
    .wdata_i    (wdata_i[REG_W-1:0]),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .mask_o     (mask_q),
    .stat_o     (stat_q),
    .irq_o      (irq_o)
  );

  dbell_tx #(.MSG_W(MSG_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (dec.bell_wr),
    .data_i  (wdata_i[MSG_W-1:0]),
    .valid_o (tx_valid_o),
    .data_o  (tx_data_o)
  );

  always_comb begin
    rdata_d = '0;
    if (dec.mask_rd)      rdata_d = {{RPAD_W{1'b0}}, mask_q};
    else if (dec.stat_rd) rdata_d = {{RPAD_W{1'b0}}, stat_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dbell_regblk_chk.sv
module dbell_regblk_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned MSG_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        size_i,
  input logic [7:0]        off_i,
  input logic [MSG_W-1:0]  wbyte_i,
  input logic              rx_valid_i,
  input logic [MSG_W-1:0]  rx_data_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic              tx_valid_o,
  input logic [MSG_W-1:0]  tx_data_o,
  input logic [REG_W-1:0]  mask_q,
  input logic [REG_W-1:0]  stat_q
);
  localparam int unsigned PAD_W = REG_W - MSG_W;

  AST_TX_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(req_i && we_i && size_i == 2'd0 && off_i == 8'd32)); // R6
  AST_TX_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_data_o == $past(wbyte_i)); // R6
  AST_RX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> stat_q == {{PAD_W{1'b0}}, $past(rx_data_i)}); // R7
  AST_STAT_RDCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == 2'd1 && off_i == 8'd16 && !rx_valid_i) |=> stat_q == '0); // R4
  AST_WORD_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == 2'd2 && !rx_valid_i)
      |=> ($stable(mask_q) && $stable(stat_q) && rdata_o == '0 && !tx_valid_o)); // R8
  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> rdata_o == '0); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o); // R2
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> stat_q != '0); // R2
endmodule

bind dbell_regblk dbell_regblk_chk #(.DATA_W(DATA_W), .REG_W(REG_W), .MSG_W(MSG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .size_i     (size_i),
  .off_i      (addr_i[7:0]),
  .wbyte_i    (wdata_i[MSG_W-1:0]),
  .rx_valid_i (rx_valid_i),
  .rx_data_i  (rx_data_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .mask_q     (mask_q),
  .stat_q     (stat_q)
);

// File: tb/sim_dbell_regblk.sv
`timescale 1ns/1ps
module sim_dbell_regblk;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, tx_valid_o;
  logic [7:0]  tx_data_o;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;

  int n_vec = 0, n_bad = 0;
  int m_mask = 0, m_stat = 0, m_rdata = 0, m_txv = 0, m_txd = 0;

  always #2.5 clk_i = ~clk_i;

  dbell_regblk u0 (.*);

  task automatic compare(input string tag);
    int e_irq;
    e_irq = ((m_mask & m_stat) != 0) ? 1 : 0;
    n_vec++;
    if (rdata_o !== 32'(m_rdata) || irq_o !== 1'(e_irq) ||
        tx_valid_o !== 1'(m_txv) || tx_data_o !== 8'(m_txd)) begin
      n_bad++;
      $display("FAIL %s rdata=%h/%h irq=%b/%0d txv=%b/%0d txd=%h/%h (actual/expected)",
               tag, rdata_o, m_rdata, irq_o, e_irq, tx_valid_o, m_txv, tx_data_o, m_txd);
    end
  endtask

  task automatic step(input string tag, input bit rq, input bit w, input int sz,
                      input int ad, input int wd, input bit rv, input int rd);
    int off, hoff, old_stat;
    req_i = rq; we_i = w; size_i = 2'(sz); addr_i = 32'(ad); wdata_i = 32'(wd);
    rx_valid_i = rv; rx_data_i = 8'(rd);
    @(posedge clk_i);
    off = ad & 255; hoff = off & 254; old_stat = m_stat;
    m_rdata = 0; m_txv = 0;
    if (rq && sz == 1) begin
      if (w) begin
        if (hoff == 0) m_mask = wd & 16'hffff;
        else if (hoff == 16) m_stat = wd & 16'hffff;
      end else begin
        if (off == 0) m_rdata = m_mask;
        else if (off == 16) begin m_rdata = old_stat; m_stat = 0; end
      end
    end
    if (rq && w && sz == 0 && off == 32) begin m_txv = 1; m_txd = wd & 255; end
    if (rv) m_stat = rd & 255;
    #1;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #12; compare("R1 reset");
    @(posedge clk_i); #1 rst_ni = 1'b1;
    idle("R9 idle");
    // R3/R4 mask write and readback
    step("R3 mask wr", 1, 1, 1, 0, 32'hdead00ff, 0, 0);
    step("R4 mask rd", 1, 0, 1, 0, 0, 0, 0);
    idle("R9 after read");
    // R7/R2 inbound loads status, irq follows
    step("R7 rx", 0, 0, 0, 0, 0, 1, 8'h05);
    step("R4 stat rd clr", 1, 0, 1, 16, 0, 0, 0);
    step("R4 stat empty", 1, 0, 1, 16, 0, 0, 0);
    step("R7 rx hi", 0, 0, 0, 0, 0, 1, 8'h80);
    step("R3 mask via bit0", 1, 1, 1, 1, 32'h0000ff00, 0, 0);
    step("R2 masked", 1, 0, 1, 0, 0, 0, 0);
    step("R3 stat wr bit0", 1, 1, 1, 17, 32'h00001234, 0, 0);
    step("R5 rd off17", 1, 0, 1, 17, 0, 0, 0);
    step("R5 rd off32", 1, 0, 1, 32, 0, 0, 0);
    step("R5 rd off1", 1, 0, 1, 1, 0, 0, 0);
    step("R3 upper addr", 1, 0, 1, 32'h00000100, 0, 0, 0);
    // R6 doorbell
    step("R6 bell", 1, 1, 0, 32, 32'h0000abcd, 0, 0);
    step("R6 bell b2b", 1, 1, 0, 32, 32'h00000042, 0, 0);
    idle("R6 pulse ends");
    idle("R6 data held");
    // R8 no-effect accesses
    step("R8 bell off33", 1, 1, 0, 33, 32'h77, 0, 0);
    step("R8 word wr", 1, 1, 2, 0, 32'hffffffff, 0, 0);
    step("R8 word rd", 1, 0, 2, 16, 0, 0, 0);
    step("R8 byte rd", 1, 0, 0, 0, 0, 0, 0);
    step("R8 rsvd wr", 1, 1, 3, 16, 32'hffff, 0, 0);
    step("R8 half wr 32", 1, 1, 1, 32, 32'hffff, 0, 0);
    step("R8 byte wr mask", 1, 1, 0, 0, 32'h11, 0, 0);
    step("R8 mask kept", 1, 0, 1, 0, 0, 0, 0);
    step("R8 stat kept", 1, 0, 1, 16, 0, 0, 0);
    // R7 priority
    step("R7 set", 1, 1, 1, 16, 32'hff00, 0, 0);
    step("R7 rd vs rx", 1, 0, 1, 16, 0, 1, 8'h9c);
    step("R7 rx kept", 1, 0, 1, 16, 0, 0, 0);
    step("R7 wr vs rx", 1, 1, 1, 16, 32'h5500, 1, 8'h03);
    step("R7 rx wins", 1, 0, 1, 16, 0, 0, 0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      int sel, ad;
      sel = $urandom_range(0, 7);
      case (sel)
        0: ad = 0; 1: ad = 1; 2: ad = 16; 3: ad = 17;
        4: ad = 32; 5: ad = 33; 6: ad = 32'h110; default: ad = $urandom_range(0, 1023);
      endcase
      step("R2 random", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           $urandom_range(0, 3), ad, $urandom, ($urandom_range(0, 5) == 0), $urandom_range(0, 255));
    end
    // R1 reset mid-run
    step("R1 pre", 1, 1, 1, 0, 32'hffff, 1, 8'h01);
    step("R1 bell", 1, 1, 0, 32, 32'h3c, 0, 0);
    req_i = 0; rx_valid_i = 0;
    rst_ni = 1'b0;
    #1;
    m_mask = 0; m_stat = 0; m_rdata = 0; m_txv = 0; m_txd = 0;
    compare("R1 async reset");
    @(posedge clk_i); #1 compare("R1 held");
    rst_ni = 1'b1;
    idle("R1 after");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule